// File: doc/BRIEF.md
# Feedback Prefetch Throttle Controller

This block sets how hard a many-thread prefetch generator is held back. The core reports three single-cycle events to it. The first marks a prefetched block that left the prefetch cache before any demand used it. The second marks a new miss request that matched an entry already outstanding in the miss-holding registers, and so merged into it. The third marks a prefetch that was issued. The block counts these events over a fixed sampling window. At the close of each window it grades the early-eviction ratio and the merge ratio against the prefetch count, and moves a throttle degree with them.

The degree runs from 0 (let every candidate prefetch through) to 5 (suppress all of them). The generator reads it as the number of candidates to drop. Each ratio is graded low, medium or high against two programmable thresholds. The thresholds are fractions in units of 1/2^THR_W and are compared by cross-multiplication, so the block needs no divider. Many prefetches evicted early means the prefetcher is too aggressive. A low eviction rate with few merges means its guesses are not accurate. A low eviction rate with many merges means prefetching is paying off.

Top module: `pf_throttle_ctrl`

## Requirements
- R1: `degree_o` is a registered value that never leaves the range 0 to 5, and a synchronous reset sets it to 2.
- R2: The degree can change only on the clock edge of the last cycle of each PERIOD-cycle window, where the window counter counts from reset release. It keeps its value on every other edge.
- R3: Each event input adds one to its own count for every cycle in which it is high. An event sampled in a window's last cycle is counted toward the next window. All counts restart at each window boundary.
- R4: With THR_W = 8, a count c against issued count n grades LOW when c*256 < lo*n. It grades HIGH when c*256 >= hi*n, and MEDIUM otherwise.
- R5: An early-eviction grade of HIGH sets the degree to 5, whatever the merge grade.
- R6: An early-eviction grade of MEDIUM raises the degree by one, and the degree stays at 5 once it is there.
- R7: An early-eviction grade of LOW together with a merge grade of HIGH lowers the degree by one, and the degree stays at 0 once it is there.
- R8: An early-eviction grade of LOW together with a merge grade of LOW sets the degree to 5.
- R9: An early-eviction grade of LOW together with a merge grade of MEDIUM leaves the degree unchanged.
- R10: A window in which no prefetch was issued leaves the degree unchanged, whatever the other counts are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evict_early_i | input | 1 | An unused prefetched block was evicted this cycle |
| merge_i | input | 1 | A new miss request merged into an outstanding entry this cycle |
| pf_issue_i | input | 1 | A prefetch was issued this cycle |
| thr_lo_i | input | THR_W | Low grading threshold, as a fraction of 2^THR_W |
| thr_hi_i | input | THR_W | High grading threshold, as a fraction of 2^THR_W |
| degree_o | output | 3 | Throttle degree, from 0 (all prefetches allowed) to 5 (none allowed) |

## Verification
The bench drives the degree against both saturation points. A design that wraps instead of saturating would drop to 7 or jump to 0. It places counts exactly on each threshold product. An off-by-one comparison would grade those windows one level away, and the degree would step instead of jumping to 5, or the reverse. It also checks that a window with no prefetches leaves the degree alone, where a design would otherwise read the empty ratios as LOW/LOW and disable prefetching. It issues a single prefetch in a window's closing cycle and expects it to count in the following window. A design that drops that event, or that counts it in the window just closed, ends with a different degree.

// File: rtl/pf_thr_pkg.sv
package pf_thr_pkg;
  typedef enum logic [1:0] {
    LVL_LOW  = 2'd0,
    LVL_MED  = 2'd1,
    LVL_HIGH = 2'd2
  } lvl_e;

  localparam int DEG_W     = 3;
  localparam int DEG_MAX   = 5;
  localparam int DEG_RESET = 2;
endpackage

// File: rtl/pf_evt_counter.sv
module pf_evt_counter #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= '0;
    end else if (clr) begin
      cnt_o <= W'(inc);
    end else if (inc && (cnt_o != '1)) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end

  AST_CLEAR_RESTART: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_o <= W'(1))); // R3
endmodule

// File: rtl/pf_ratio_class.sv
module pf_ratio_class
  import pf_thr_pkg::*;
#(
  parameter int CNT_W = 11,
  parameter int THR_W = 8
) (
  input  logic [CNT_W-1:0] num_i,
  input  logic [CNT_W-1:0] den_i,
  input  logic [THR_W-1:0] lo_i,
  input  logic [THR_W-1:0] hi_i,
  output lvl_e             lvl_o
);
  localparam int PW = CNT_W + THR_W;

  logic [PW-1:0] num_scaled;
  logic [PW-1:0] lo_prod;
  logic [PW-1:0] hi_prod;

  always_comb begin
    num_scaled = PW'(num_i) << THR_W;
    lo_prod    = PW'(lo_i) * PW'(den_i);
    hi_prod    = PW'(hi_i) * PW'(den_i);
    if (num_scaled >= hi_prod)     lvl_o = LVL_HIGH;
    else if (num_scaled < lo_prod) lvl_o = LVL_LOW;
    else                           lvl_o = LVL_MED;
  end
endmodule

// File: rtl/pf_degree_ctl.sv
module pf_degree_ctl
  import pf_thr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             close_i,
  input  logic             iss_zero_i,
  input  lvl_e             ev_lvl_i,
  input  lvl_e             mg_lvl_i,
  output logic [DEG_W-1:0] degree_o
);
  localparam logic [DEG_W-1:0] DMAX = DEG_W'(DEG_MAX);
  localparam logic [DEG_W-1:0] DRST = DEG_W'(DEG_RESET);

  logic [DEG_W-1:0] deg_nxt;

  always_comb begin
    deg_nxt = degree_o;
    if (close_i && !iss_zero_i) begin
      unique case (ev_lvl_i)
        LVL_HIGH: deg_nxt = DMAX;
        LVL_MED:  deg_nxt = (degree_o == DMAX) ? DMAX : degree_o + 1'b1;
        default: begin
          if (mg_lvl_i == LVL_HIGH)
            deg_nxt = (degree_o == '0) ? '0 : degree_o - 1'b1;
          else if (mg_lvl_i == LVL_LOW)
            deg_nxt = DMAX;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) degree_o <= DRST;
    else     degree_o <= deg_nxt;
  end

  AST_DEG_RANGE: assert property (@(posedge clk) disable iff (rst)
    degree_o <= DMAX); // R1
  AST_HOLD_OPEN: assert property (@(posedge clk) disable iff (rst)
    !close_i |=> $stable(degree_o)); // R2
  AST_HOLD_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (close_i && iss_zero_i) |=> $stable(degree_o)); // R10
  AST_EVICT_HIGH: assert property (@(posedge clk) disable iff (rst)
    (close_i && !iss_zero_i && ev_lvl_i == LVL_HIGH) |=> degree_o == DMAX); // R5
  AST_INACCURATE: assert property (@(posedge clk) disable iff (rst)
    (close_i && !iss_zero_i && ev_lvl_i == LVL_LOW && mg_lvl_i == LVL_LOW)
      |=> degree_o == DMAX); // R8
  AST_MID_HOLD: assert property (@(posedge clk) disable iff (rst)
    (close_i && !iss_zero_i && ev_lvl_i == LVL_LOW && mg_lvl_i == LVL_MED)
      |=> $stable(degree_o)); // R9
endmodule

// File: rtl/pf_throttle_ctrl.sv
module pf_throttle_ctrl
  import pf_thr_pkg::*;
#(
  parameter int PERIOD = 1024,
  parameter int THR_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evict_early_i,
  input  logic             merge_i,
  input  logic             pf_issue_i,
  input  logic [THR_W-1:0] thr_lo_i,
  input  logic [THR_W-1:0] thr_hi_i,
  output logic [2:0]       degree_o
);
  localparam int PER_W  = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam int CNT_W  = $clog2(PERIOD + 1);
  localparam int N_EVT  = 3;
  localparam int IDX_EV = 0;
  localparam int IDX_MG = 1;
  localparam int IDX_PF = 2;

  logic [PER_W-1:0] pcnt;
  logic             close;
  logic [N_EVT-1:0] evt;
  logic [CNT_W-1:0] cnt [N_EVT];
  lvl_e             lvl [2];

  assign close = (pcnt == PER_W'(PERIOD - 1));
  assign evt   = {pf_issue_i, merge_i, evict_early_i};

  always_ff @(posedge clk) begin
    if (rst || close) pcnt <= '0;
    else              pcnt <= pcnt + 1'b1;
  end

  for (genvar g = 0; g < N_EVT; g++) begin : g_cnt
    pf_evt_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .clr   (close),
      .inc   (evt[g]),
      .cnt_o (cnt[g])
    );
  end

  for (genvar g = 0; g < 2; g++) begin : g_cls
    pf_ratio_class #(.CNT_W(CNT_W), .THR_W(THR_W)) u_cls (
      .num_i (cnt[g]),
      .den_i (cnt[IDX_PF]),
      .lo_i  (thr_lo_i),
      .hi_i  (thr_hi_i),
      .lvl_o (lvl[g])
    );
  end

  pf_degree_ctl u_deg (
    .clk        (clk),
    .rst        (rst),
    .close_i    (close),
    .iss_zero_i (cnt[IDX_PF] == '0),
    .ev_lvl_i   (lvl[IDX_EV]),
    .mg_lvl_i   (lvl[IDX_MG]),
    .degree_o   (degree_o)
  );

  AST_WINDOW_WRAP: assert property (@(posedge clk) disable iff (rst)
    close |=> (pcnt == '0)); // R2
endmodule

// File: tb/pf_throttle_ctrl_tb.sv
`timescale 1ns/1ps
module pf_throttle_ctrl_tb;
  localparam int PERIOD = 32;
  localparam int THR_W  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic evict_early_i = 1'b0, merge_i = 1'b0, pf_issue_i = 1'b0;
  logic [THR_W-1:0] thr_lo_i = 8'd64, thr_hi_i = 8'd160;
  logic [2:0] degree_o;

  int checks = 0, errors = 0, ecount = 0;
  int exp_q[$];
  int model_deg = 2, carry_pf = 0, cur_exp = 2;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pf_throttle_ctrl #(.PERIOD(PERIOD), .THR_W(THR_W)) u_dut (
    .clk(clk), .rst(rst), .evict_early_i(evict_early_i), .merge_i(merge_i),
    .pf_issue_i(pf_issue_i), .thr_lo_i(thr_lo_i), .thr_hi_i(thr_hi_i),
    .degree_o(degree_o)
  );

  // grade: 0 LOW, 1 MED, 2 HIGH (R4)
  function automatic int grade(int c, int n, int lo, int hi);
    if (c * 256 >= hi * n) return 2;
    if (c * 256 < lo * n)  return 0;
    return 1;
  endfunction

  function automatic int next_deg(int d, int ne, int nm, int ni, int lo, int hi);
    int ge, gm;
    if (ni == 0) return d;                    // R10
    ge = grade(ne, ni, lo, hi);
    gm = grade(nm, ni, lo, hi);
    if (ge == 2) return 5;                    // R5
    if (ge == 1) return (d == 5) ? 5 : d + 1; // R6
    if (gm == 2) return (d == 0) ? 0 : d - 1; // R7
    if (gm == 0) return 5;                    // R8
    return d;                                 // R9
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s degree actual %0d expected %0d", req, act, exp);
    end
  endtask

  // driver: one window; tail puts a single issue on the closing cycle (R3)
  task automatic run_period(int ne, int nm, int ni, bit tail, int lo, int hi);
    int ni_eff = ni + carry_pf;
    model_deg = next_deg(model_deg, ne, nm, ni_eff, lo, hi);
    exp_q.push_back(model_deg);
    carry_pf = tail ? 1 : 0;
    thr_lo_i = THR_W'(lo);
    thr_hi_i = THR_W'(hi);
    for (int i = 0; i < PERIOD; i++) begin
      evict_early_i = (i < ne);
      merge_i       = (i < nm);
      pf_issue_i    = (i < ni) || (tail && i == PERIOD - 1);
      @(negedge clk);
    end
    evict_early_i = 1'b0; merge_i = 1'b0; pf_issue_i = 1'b0;
  endtask

  always @(posedge clk) begin
    if (rst) ecount <= 0;
    else     ecount <= ecount + 1;
  end

  // monitor: compares at every window close, checks hold in between (R2)
  always @(negedge clk) begin
    if (!rst && !done && ecount > 0) begin
      if (ecount % PERIOD == 0) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 queue-empty", int'(degree_o), -1);
        end else begin
          cur_exp = exp_q.pop_front();
          check(int'(degree_o) == cur_exp, "R4-R10 window", int'(degree_o), cur_exp);
        end
      end else begin
        check(int'(degree_o) == cur_exp, "R2 hold", int'(degree_o), cur_exp);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog degree actual %0d expected %0d", degree_o, cur_exp);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(degree_o == 3'd2, "R1 reset", int'(degree_o), 2);
    rst = 1'b0;
    run_period(0, 20, 20, 0, 64, 160);   // R7 2->1
    run_period(0, 20, 20, 0, 64, 160);   // R7 1->0
    run_period(0, 20, 20, 0, 64, 160);   // R7 saturate at 0
    run_period(8, 0, 20, 0, 64, 160);    // R6 0->1
    run_period(8, 0, 20, 0, 64, 160);    // R6
    run_period(8, 0, 20, 0, 64, 160);    // R6
    run_period(8, 0, 20, 0, 64, 160);    // R6
    run_period(8, 0, 20, 0, 64, 160);    // R6 ->5
    run_period(8, 0, 20, 0, 64, 160);    // R6 saturate at 5, R1
    run_period(10, 10, 0, 0, 64, 160);   // R10 no issue
    run_period(0, 20, 20, 0, 64, 160);   // R7 5->4
    run_period(0, 10, 20, 0, 64, 160);   // R9 merge medium
    run_period(0, 2, 20, 0, 64, 160);    // R8 low/low ->5
    run_period(0, 20, 20, 0, 64, 160);   // R7 ->4
    run_period(5, 20, 20, 0, 64, 160);   // R4 lo boundary 1280==1280 -> MED, R6 ->5
    run_period(0, 20, 20, 0, 64, 160);   // ->4
    run_period(0, 20, 20, 0, 64, 160);   // ->3
    run_period(5, 8, 8, 0, 64, 160);     // R4 hi boundary 1280==1280 -> HIGH, R5 ->5
    run_period(0, 20, 20, 0, 64, 160);   // ->4
    run_period(8, 20, 20, 0, 64, 100);   // R4 programmable hi: 2048>=2000, R5 ->5
    run_period(0, 20, 20, 0, 64, 160);   // ->4
    run_period(15, 20, 20, 0, 64, 160);  // R5 ->5
    run_period(0, 20, 20, 0, 64, 160);   // ->4
    run_period(0, 0, 0, 1, 64, 160);     // R3 tail issue; this window empty, hold
    run_period(0, 0, 0, 0, 64, 160);     // R3 carried issue: low/low ->5
    run_period(0, 0, 0, 0, 64, 160);     // R3 counts cleared: empty, hold
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule